// File: doc/BRIEF.md
# Mapped Interrupt Request Dispatcher

The dispatcher gathers 64 level-sensitive interrupt sources and presents at most one of them at a time on a bank of 64 request lines. Sources 0 to 31 come from expansion slots and sources 32 to 63 from on-board peripherals. Request line n belongs to source n. Each source is gated by the top bit of a mapping register. Slot sources share one mapping register per group of four. Each on-board source has a register of its own.

Software reaches the mapping registers and the clear registers through a 32-bit register port. Writes are single-cycle strobes and reads are combinational. Once a request has been issued it stays up until software clears it, drops its enable, or a rising slot source displaces it. After that the dispatcher chooses again among the enabled sources that are still pending. Arbitration is a combinational priority encode that runs every cycle. It sees the input levels and register writes of that cycle, and its result is registered at the clock edge.

Top module: `irq_vector_dispatch`

## Requirements
- R1: A synchronous reset clears every enable bit, every input latch and the outstanding request, so all request lines are low. Mapping register g of the slot group (g = 0..7) then reads 0x000007C0 + 4*g, and on-board mapping register k (k = 0..31) reads 0x000007E0 + k.
- R2: Request line n is high exactly while n is the outstanding request index. At most one line is high, and "none" is kept internally as index 65.
- R3: With no request outstanding, the lowest-numbered source that is pending and enabled is issued at the next clock edge. Slot sources 0..31 therefore come before on-board sources 32..63.
- R4: Slot source i is enabled by bit 31 of slot mapping register i/4. On-board source 32+k is enabled by bit 31 of on-board mapping register k.
- R5: An outstanding request stays asserted when its input falls, and when other on-board sources rise or become enabled, until it is dropped.
- R6: A slot source that rises while enabled takes the request at the next edge, even when another request is outstanding. If several rise together, the lowest index wins.
- R7: A write to a mapping register stores only bit 31, and the low 31 bits keep their reset value. Writing 0 to bit 31 for the group or source of the outstanding request drops that request, and arbitration runs again in the same cycle.
- R8: A write to slot clear register g drops the outstanding request only when its index divided by 4 equals g, and arbitration then runs again. Otherwise the write has no effect.
- R9: A write to on-board clear register k drops the outstanding request only when its index equals 32+k, and arbitration then runs again. Otherwise the write has no effect.
- R10: Each register sits at +4 of an 8-byte slot. Slot mapping registers are at 0x0C04 + 8*g and on-board mapping registers at 0x1004 + 8*k. Slot clear registers are at 0x1404 + 32*g and on-board clear registers at 0x1804 + 8*k. Writes to the +0 word are ignored, and the +0 word and all clear registers read as zero.
- R11: A source whose enable bit is 0 never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt sources; 0..31 slots, 32..63 on-board |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| ivec_o | output | 64 | Request lines, at most one high |

## Verification
On every cycle the assertions check the following:
- At most one request line is high.
- Lines are quiet after reset, and stay quiet when nothing is pending.
- A request is held steady when no write and no slot rising edge is present.
- An exact on-board clear removes a request whose source is low.
- The +0 word reads zero.

Some behaviour only the bench scenarios can show. These are the priority order between slot and on-board sources, the group-of-four enable and clear rules, displacement by a rising slot source, reselection after a drop, and the stored values behind the mapping registers.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int unsigned PCI_SRCS  = 32;
    localparam int unsigned OBIO_SRCS = 32;
    localparam int unsigned GRP_SIZE  = 4;
    localparam int unsigned SRC_N     = PCI_SRCS + OBIO_SRCS;
    localparam int unsigned PCI_MAPS  = PCI_SRCS / GRP_SIZE;
    localparam int unsigned IDX_W     = 7;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ROUTE_W   = DATA_W - 1;

    typedef logic [IDX_W-1:0] req_idx_t;
    localparam req_idx_t REQ_NONE = req_idx_t'(65);

    // window bases; the low bits carry the register index
    localparam logic [ADDR_W-1:0] PCI_MAP_BASE  = 16'h0C00;
    localparam logic [ADDR_W-1:0] OBIO_MAP_BASE = 16'h1000;
    localparam logic [ADDR_W-1:0] PCI_CLR_BASE  = 16'h1400;
    localparam logic [ADDR_W-1:0] OBIO_CLR_BASE = 16'h1800;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_PCI_MAP,
        RGN_OBIO_MAP,
        RGN_PCI_CLR,
        RGN_OBIO_CLR
    } rgn_e;

    typedef struct packed {
        rgn_e       rgn;
        logic       upper;
        logic [4:0] idx;
    } cfg_dec_t;

    typedef struct packed {
        logic     valid;
        req_idx_t idx;
    } pick_t;

    function automatic cfg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        cfg_dec_t d;
        d.rgn   = RGN_NONE;
        d.upper = a[2];
        d.idx   = '0;
        if (a[15:6] == PCI_MAP_BASE[15:6]) begin
            d.rgn = RGN_PCI_MAP;
            d.idx = {2'b00, a[5:3]};
        end else if (a[15:8] == OBIO_MAP_BASE[15:8]) begin
            d.rgn = RGN_OBIO_MAP;
            d.idx = a[7:3];
        end else if (a[15:8] == PCI_CLR_BASE[15:8]) begin
            d.rgn = RGN_PCI_CLR;
            d.idx = {2'b00, a[7:5]};
        end else if (a[15:8] == OBIO_CLR_BASE[15:8]) begin
            d.rgn = RGN_OBIO_CLR;
            d.idx = a[7:3];
        end
        return d;
    endfunction

    function automatic logic [ROUTE_W-1:0] pci_route_rst(input int unsigned g);
        return ROUTE_W'((32'h1F << 6) | (g << 2));
    endfunction

    function automatic logic [ROUTE_W-1:0] obio_route_rst(input int unsigned k);
        return ROUTE_W'(((32'h1F << 6) | 32'h20) + k);
    endfunction

    // lowest set bit of a source vector
    function automatic pick_t lowest_set(input logic [SRC_N-1:0] v);
        pick_t p;
        p.valid = 1'b0;
        p.idx   = REQ_NONE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = req_idx_t'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg
    import irqd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  req_idx_t            req_q,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic [PCI_MAPS-1:0] pci_en_nxt,
    output logic [OBIO_SRCS-1:0] obio_en_nxt,
    output logic                drop
);
    logic [PCI_MAPS-1:0]  pci_en_q;
    logic [OBIO_SRCS-1:0] obio_en_q;
    logic [ROUTE_W-1:0]   pci_route  [PCI_MAPS];
    logic [ROUTE_W-1:0]   obio_route [OBIO_SRCS];

    // routing fields are never written, so they are fixed values
    for (genvar g = 0; g < PCI_MAPS; g++) begin : g_pci_route
        assign pci_route[g] = pci_route_rst(g);
    end
    for (genvar k = 0; k < OBIO_SRCS; k++) begin : g_obio_route
        assign obio_route[k] = obio_route_rst(k);
    end

    cfg_dec_t dec;
    logic     wr_ok;
    logic     en_bit;
    logic     req_is_pci;
    logic     req_is_obio;

    assign dec         = decode_addr(cfg_addr);
    assign wr_ok       = cfg_we && dec.upper;
    assign en_bit      = cfg_wdata[DATA_W-1];
    assign req_is_pci  = (req_q[6:5] == 2'b00);
    assign req_is_obio = (req_q[6:5] == 2'b01);

    always_comb begin
        pci_en_nxt  = pci_en_q;
        obio_en_nxt = obio_en_q;
        if (wr_ok && dec.rgn == RGN_PCI_MAP)
            pci_en_nxt[dec.idx[2:0]] = en_bit;
        if (wr_ok && dec.rgn == RGN_OBIO_MAP)
            obio_en_nxt[dec.idx] = en_bit;
    end

    always_comb begin
        drop = 1'b0;
        if (wr_ok) begin
            unique case (dec.rgn)
                RGN_PCI_MAP:
                    drop = !en_bit && req_is_pci && (req_q[4:2] == dec.idx[2:0]);
                RGN_OBIO_MAP:
                    drop = !en_bit && req_is_obio && (req_q[4:0] == dec.idx);
                RGN_PCI_CLR:
                    drop = (req_q[6:2] == {2'b00, dec.idx[2:0]});
                RGN_OBIO_CLR:
                    drop = req_is_obio && (req_q[4:0] == dec.idx);
                default:
                    drop = 1'b0;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (dec.upper) begin
            if (dec.rgn == RGN_PCI_MAP)
                cfg_rdata = {pci_en_q[dec.idx[2:0]], pci_route[dec.idx[2:0]]};
            else if (dec.rgn == RGN_OBIO_MAP)
                cfg_rdata = {obio_en_q[dec.idx], obio_route[dec.idx]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pci_en_q  <= '0;
            obio_en_q <= '0;
        end else begin
            pci_en_q  <= pci_en_nxt;
            obio_en_q <= obio_en_nxt;
        end
    end

endmodule

// File: rtl/irqd_pick.sv
module irqd_pick
    import irqd_pkg::*;
(
    input  logic [SRC_N-1:0]     pend,
    input  logic [SRC_N-1:0]     rise,
    input  logic [PCI_MAPS-1:0]  pci_en,
    input  logic [OBIO_SRCS-1:0] obio_en,
    output pick_t                any_pick,
    output pick_t                pci_rise_pick
);
    logic [SRC_N-1:0] en_src;

    // slot sources share an enable per group; on-board ones have their own
    for (genvar i = 0; i < SRC_N; i++) begin : g_en
        if (i < PCI_SRCS) begin : g_pci
            assign en_src[i] = pci_en[i / GRP_SIZE];
        end else begin : g_obio
            assign en_src[i] = obio_en[i - PCI_SRCS];
        end
    end

    assign any_pick      = lowest_set(pend & en_src);
    assign pci_rise_pick = lowest_set({{OBIO_SRCS{1'b0}},
                                       rise[PCI_SRCS-1:0] & en_src[PCI_SRCS-1:0]});

endmodule

// File: rtl/irqd_track.sv
module irqd_track
    import irqd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     drop,
    input  pick_t    any_pick,
    input  pick_t    pci_rise_pick,
    output req_idx_t req_q
);
    req_idx_t held;
    req_idx_t req_nxt;

    assign held = drop ? REQ_NONE : req_q;

    always_comb begin
        if (pci_rise_pick.valid)
            req_nxt = pci_rise_pick.idx;
        else if (held != REQ_NONE)
            req_nxt = held;
        else if (any_pick.valid)
            req_nxt = any_pick.idx;
        else
            req_nxt = REQ_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= REQ_NONE;
        else     req_q <= req_nxt;
    end

endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
    import irqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       irq_in,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [63:0]       ivec_o
);
    logic [SRC_N-1:0]     lvl_q;
    logic [SRC_N-1:0]     rise;
    logic [PCI_MAPS-1:0]  pci_en_nxt;
    logic [OBIO_SRCS-1:0] obio_en_nxt;
    logic                 drop;
    pick_t                any_pick;
    pick_t                pci_rise_pick;
    req_idx_t             req_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= irq_in;
    end

    assign rise = irq_in & ~lvl_q;

    irqd_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .req_q       (req_q),
        .cfg_rdata   (cfg_rdata),
        .pci_en_nxt  (pci_en_nxt),
        .obio_en_nxt (obio_en_nxt),
        .drop        (drop)
    );

    irqd_pick u_pick (
        .pend          (irq_in),
        .rise          (rise),
        .pci_en        (pci_en_nxt),
        .obio_en       (obio_en_nxt),
        .any_pick      (any_pick),
        .pci_rise_pick (pci_rise_pick)
    );

    irqd_track u_track (
        .clk           (clk),
        .rst           (rst),
        .drop          (drop),
        .any_pick      (any_pick),
        .pci_rise_pick (pci_rise_pick),
        .req_q         (req_q)
    );

    for (genvar n = 0; n < SRC_N; n++) begin : g_line
        assign ivec_o[n] = (req_q == req_idx_t'(n));
    end

endmodule

// File: rtl/irqd_chk.sv
module irqd_chk (
    input logic        clk,
    input logic        rst,
    input logic [63:0] irq_in,
    input logic [63:0] lvl_q,
    input logic        cfg_we,
    input logic [15:0] cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic [63:0] ivec_o
);
    logic       obio_clr_hit;
    logic [5:0] line_sel;
    logic [5:0] hit_line;

    assign line_sel     = {1'b1, cfg_addr[7:3]};
    assign obio_clr_hit = cfg_we && (cfg_addr[15:8] == 8'h18) && cfg_addr[2]
                          && ivec_o[line_sel] && !irq_in[line_sel];

    always_ff @(posedge clk) hit_line <= line_sel;

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ivec_o)); // R2

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ivec_o == '0)); // R1

    AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && (ivec_o != '0) && ((irq_in[31:0] & ~lvl_q[31:0]) == '0))
        |=> $stable(ivec_o)); // R5

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((ivec_o == '0) && (irq_in == '0)) |=> (ivec_o == '0)); // R11

    AST_OBIO_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        obio_clr_hit |=> !ivec_o[hit_line]); // R9

    AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_addr[2] |-> (cfg_rdata == '0)); // R10

endmodule

bind irq_vector_dispatch irqd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .lvl_q     (lvl_q),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .ivec_o    (ivec_o)
);

// File: tb/irq_vector_dispatch_tb.sv
module irq_vector_dispatch_tb;

    localparam int NONE = 65;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] irq_in;
    logic        cfg_we;
    logic [15:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [63:0] ivec_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_vector_dispatch u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ivec_o    (ivec_o)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [63:0] irq;
        logic [6:0]  exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0020, 7'd65}, // R11 nothing enabled
        '{1'b1, 16'h0C0C, 32'h8000_0000, 64'h0000_0100_0000_0020, 7'd5 }, // R3 R4 group 1 on
        '{1'b1, 16'h1044, 32'h8000_0000, 64'h0000_0100_0000_0020, 7'd5 }, // R5 on-board 8 on
        '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0000, 7'd5 }, // R5 input fell
        '{1'b1, 16'h1844, 32'h0,         64'h0000_0100_0000_0000, 7'd5 }, // R9 no match
        '{1'b1, 16'h1404, 32'h0,         64'h0000_0100_0000_0000, 7'd5 }, // R8 wrong group
        '{1'b1, 16'h1424, 32'h0,         64'h0000_0100_0000_0000, 7'd40}, // R8 group hit
        '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0040, 7'd6 }, // R6 slot rise
        '{1'b1, 16'h104C, 32'h8000_0000, 64'h0000_0300_0000_0040, 7'd6 }, // R5 on-board rise
        '{1'b1, 16'h0C0C, 32'h0,         64'h0000_0300_0000_0040, 7'd40}, // R7 disable drops
        '{1'b1, 16'h1844, 32'h0,         64'h0000_0200_0000_0040, 7'd41}, // R9 exact hit
        '{1'b1, 16'h184C, 32'h0,         64'h0000_0000_0000_0040, 7'd65}, // R9 R11 rest off
        '{1'b1, 16'h0C04, 32'h8000_0000, 64'h0000_0000_0000_004A, 7'd1 }, // R3 R6 lowest
        '{1'b0, 16'h0000, 32'h0,         64'h0000_0000_0000_004E, 7'd2 }, // R6 displaces
        '{1'b1, 16'h0C00, 32'h0,         64'h0000_0000_0000_004E, 7'd2 }, // R10 +0 map ignored
        '{1'b1, 16'h1400, 32'h0,         64'h0000_0000_0000_004E, 7'd2 }, // R10 +0 clear ignored
        '{1'b1, 16'h1404, 32'h0,         64'h0000_0000_0000_004E, 7'd1 }  // R8 R3 reselect
    };

    function automatic logic [63:0] line_of(input int idx);
        return (idx == NONE) ? 64'h0 : (64'h1 << idx);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic we, input logic [15:0] a, input logic [31:0] d,
                         input logic [63:0] irq);
        cfg_we    = we;
        cfg_addr  = a;
        cfg_wdata = d;
        irq_in    = irq;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        cfg_we   = 1'b0;
        cfg_addr = a;
        #1;
        check(req, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; irq_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 lines after reset", ivec_o, 64'h0);
        read_chk("R1 slot map 0", 16'h0C04, 32'h0000_07C0);
        read_chk("R1 slot map 7", 16'h0C3C, 32'h0000_07DC);
        read_chk("R1 board map 0", 16'h1004, 32'h0000_07E0);
        read_chk("R1 board map 31", 16'h10FC, 32'h0000_07FF);

        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].irq);
            check($sformatf("R2 vector %0d", i), ivec_o, line_of(int'(VECS[i].exp)));
        end

        // R7 stored enable with fixed routing bits
        read_chk("R7 map 0 enabled", 16'h0C04, 32'h8000_07C0);
        cycle(1'b1, 16'h0C04, 32'h0000_1234, 64'h4E);
        check("R7 disable drops, nothing left", ivec_o, 64'h0);
        read_chk("R7 low bits kept", 16'h0C04, 32'h0000_07C0);
        read_chk("R10 clear reads zero", 16'h1404, 32'h0);
        read_chk("R10 low word reads zero", 16'h1000, 32'h0);

        // R4 top on-board source and its own register
        cycle(1'b1, 16'h10FC, 32'h8000_0000, 64'h8000_0000_0000_0000);
        check("R4 source 63", ivec_o, line_of(63));
        read_chk("R4 board map 31 on", 16'h10FC, 32'h8000_07FF);

        // R1 reset mid-run
        irq_in = 64'h8000_0000_0000_0000;
        do_reset();
        check("R1 reset clears request", ivec_o, 64'h0);
        read_chk("R1 reset clears enable", 16'h10FC, 32'h0000_07FF);
        cycle(1'b0, 16'h0, 32'h0, 64'h8000_0000_0000_0000);
        check("R11 pending but disabled", ivec_o, 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule